// File: doc/BRIEF.md
# Alias Detection Register File

This block is a small, directly indexed file of alias registers used to catch wrong guesses when memory operations have been reordered speculatively. Each memory operation presented to the block can store its byte range in one register chosen by the operation. It can also compare its own byte range against any subset of registers, which it names with a bit mask. The range is a 32-bit byte address and a 2-bit log2 access size. If a compared register is occupied and its range overlaps the operation's range, the speculative reordering was unsafe, and the block raises a fault. The fault names the lowest matching register.

Both parts of an operation are optional, and they can be combined. A store may record itself in one register while the same operation is checked against others. The check always sees the register contents from before that operation's own update. A flush input empties the whole file when a speculative region commits or aborts. After a reported fault the file empties itself, because the region will be re-executed.

Top module: `alias_guard_file`

## Requirements
- R1: After reset, fault_o is 0, fault_idx_o is 0, and every register is empty, so a check of all registers raises no fault.
- R2: An operation with op_valid_i=1, op_set_en_i=1 and op_set_idx_i below NUM_SLOTS (14) stores op_addr_i and op_size_i in that register and marks it occupied. The stored range can be hit by checks from the next cycle on.
- R3: A checked register hits when it is occupied, its bit in op_chk_mask_i (bit k selects register k) is 1, and the byte ranges [base, base + 2^size - 1] of the register and of the operation intersect. The ranges are computed in 33 bits, so they do not wrap past address 0xFFFFFFFF.
- R4: A register that is empty, not selected by the mask, or whose range does not intersect the operation's range never causes a fault.
- R5: When one operation both checks and stores, the check uses the register contents from before the store.
- R6: A hit in cycle t makes fault_o 1 for exactly cycle t+1, with fault_idx_o set to the lowest matching register index. fault_idx_o is 0 whenever fault_o is 0.
- R7: In the cycle in which fault_o is 1, all registers are emptied. An operation presented in that cycle is ignored: it makes no store and raises no fault.
- R8: flush_i=1 empties all registers in one cycle. An operation in the same cycle is ignored, and no fault follows.
- R9: An operation with op_valid_i=0, or a store with op_set_idx_i of NUM_SLOTS or above (14 or 15), changes no register.
- R10: Storing into an occupied register replaces its previous range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty all registers; overrides any operation in the same cycle |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_addr_i | input | 32 | Byte address of the operation |
| op_size_i | input | 2 | log2 of the access size in bytes (1, 2, 4 or 8) |
| op_set_en_i | input | 1 | Store this operation's range in a register |
| op_set_idx_i | input | 4 | Register that receives the range |
| op_chk_mask_i | input | 14 | Registers to compare against, bit k for register k |
| fault_o | output | 1 | One-cycle alias fault pulse |
| fault_idx_o | output | 4 | Lowest register index that matched |

## Verification
A corrupted register shows up only when a later operation checks it: a stale occupied bit or a wrong base appears as a spurious or missing fault_o one cycle after that check, while a register that is never checked stays hidden. A wrong clear after a fault or a flush shows up as a fault on the next check that overlaps a range that should have been removed. The bench therefore follows every store with checks at a sweep of offsets and sizes, and issues a check right after each flush and each fault. Every output cycle is compared against an arithmetic range model.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned LG_W   = 2;
    localparam int unsigned EXT_W  = ADDR_W + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LG_W-1:0]   lg_t;
    typedef logic [EXT_W-1:0]  ext_t;

    typedef struct packed {
        logic  vld;
        addr_t base;
        lg_t   lg;
    } slot_t;

    // Last byte touched by an access, one bit wider so no wrap occurs.
    function automatic ext_t last_byte(input addr_t base, input lg_t lg);
        return {1'b0, base} + (ext_t'(1) << lg) - ext_t'(1);
    endfunction

endpackage

// File: rtl/alias_range_cmp.sv
module alias_range_cmp
    import alias_guard_pkg::*;
(
    input  logic  live_i,
    input  addr_t slot_base_i,
    input  lg_t   slot_lg_i,
    input  addr_t op_base_i,
    input  lg_t   op_lg_i,
    output logic  hit_o
);

    ext_t slot_lo, slot_hi, op_lo, op_hi;

    always_comb begin
        slot_lo = {1'b0, slot_base_i};
        op_lo   = {1'b0, op_base_i};
        slot_hi = last_byte(slot_base_i, slot_lg_i);
        op_hi   = last_byte(op_base_i, op_lg_i);
        hit_o   = live_i && (slot_lo <= op_hi) && (op_lo <= slot_hi);
    end

endmodule

// File: rtl/alias_lowest_sel.sv
module alias_lowest_sel #(
    parameter int unsigned NUM   = 14,
    parameter int unsigned IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/alias_guard_file.sv
module alias_guard_file
    import alias_guard_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 14,
    localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 flush_i,
    input  logic                 op_valid_i,
    input  logic [ADDR_W-1:0]    op_addr_i,
    input  logic [LG_W-1:0]      op_size_i,
    input  logic                 op_set_en_i,
    input  logic [IDX_W-1:0]     op_set_idx_i,
    input  logic [NUM_SLOTS-1:0] op_chk_mask_i,
    output logic                 fault_o,
    output logic [IDX_W-1:0]     fault_idx_o
);

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slots;
        logic                  fault;
        logic [IDX_W-1:0]      fault_idx;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] vld_vec;
    logic [NUM_SLOTS-1:0] hit_vec;
    logic                 hit_any;
    logic [IDX_W-1:0]     hit_idx;
    logic                 wipe;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign vld_vec[g] = st_q.slots[g].vld;

        alias_range_cmp u_cmp (
            .live_i      (vld_vec[g] & op_valid_i & op_chk_mask_i[g]),
            .slot_base_i (st_q.slots[g].base),
            .slot_lg_i   (st_q.slots[g].lg),
            .op_base_i   (op_addr_i),
            .op_lg_i     (op_size_i),
            .hit_o       (hit_vec[g])
        );
    end

    alias_lowest_sel #(
        .NUM   (NUM_SLOTS),
        .IDX_W (IDX_W)
    ) u_sel (
        .req_i (hit_vec),
        .any_o (hit_any),
        .idx_o (hit_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.fault     = 1'b0;
        st_d.fault_idx = '0;
        wipe           = flush_i | st_q.fault;

        if (wipe) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                st_d.slots[k].vld = 1'b0;
            end
        end else if (op_valid_i) begin
            if (hit_any) begin
                st_d.fault     = 1'b1;
                st_d.fault_idx = hit_idx;
            end
            if (op_set_en_i) begin
                for (int k = 0; k < NUM_SLOTS; k++) begin
                    if (op_set_idx_i == IDX_W'(k)) begin
                        st_d.slots[k].vld  = 1'b1;
                        st_d.slots[k].base = op_addr_i;
                        st_d.slots[k].lg   = op_size_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o     = st_q.fault;
    assign fault_idx_o = st_q.fault_idx;

endmodule

// File: rtl/alias_guard_file_chk.sv
module alias_guard_file_chk #(
    parameter int unsigned NUM_SLOTS = 14,
    parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 flush_i,
    input logic                 op_valid_i,
    input logic [NUM_SLOTS-1:0] op_chk_mask_i,
    input logic                 fault_o,
    input logic [IDX_W-1:0]     fault_idx_o,
    input logic [NUM_SLOTS-1:0] slot_vld_i
);

    logic [NUM_SLOTS-1:0] mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
        end else begin
            mask_q <= op_valid_i ? op_chk_mask_i : '0;
        end
    end

    // R3: a fault names a register that the previous operation selected
    assert_fault_selected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (fault_idx_o < IDX_W'(NUM_SLOTS)) && mask_q[fault_idx_o]);

    // R6: fault is a single-cycle pulse
    assert_fault_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> !fault_o);

    // R6: index reads zero when idle
    assert_idx_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fault_o |-> fault_idx_o == '0);

    // R7: the file is empty after a fault cycle
    assert_fault_wipes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |=> slot_vld_i == '0);

    // R8: flush empties the file and suppresses a fault
    assert_flush_wipes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (slot_vld_i == '0) && !fault_o);

    // R9: no operation, no fault
    assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |=> !fault_o);

    // R9: without an operation, no register becomes occupied
    assert_idle_no_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_valid_i |=> $countones(slot_vld_i) <= $countones($past(slot_vld_i)));

endmodule

bind alias_guard_file alias_guard_file_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .op_valid_i    (op_valid_i),
    .op_chk_mask_i (op_chk_mask_i),
    .fault_o       (fault_o),
    .fault_idx_o   (fault_idx_o),
    .slot_vld_i    (vld_vec)
);

// File: tb/alias_guard_file_tb_top.sv
`timescale 1ns/1ps
module alias_guard_file_tb_top;

    localparam int N = 14;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        flush_i = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [31:0] op_addr_i = '0;
    logic [1:0]  op_size_i = '0;
    logic        op_set_en_i = 1'b0;
    logic [3:0]  op_set_idx_i = '0;
    logic [N-1:0] op_chk_mask_i = '0;
    logic        fault_o;
    logic [3:0]  fault_idx_o;

    int n_chk = 0;
    int n_fail = 0;

    bit     m_vld [N];
    longint m_base[N];
    int     m_lg  [N];
    bit     m_fault = 1'b0;
    int     m_idx = 0;

    always #2 clk = ~clk;

    alias_guard_file dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .flush_i       (flush_i),
        .op_valid_i    (op_valid_i),
        .op_addr_i     (op_addr_i),
        .op_size_i     (op_size_i),
        .op_set_en_i   (op_set_en_i),
        .op_set_idx_i  (op_set_idx_i),
        .op_chk_mask_i (op_chk_mask_i),
        .fault_o       (fault_o),
        .fault_idx_o   (fault_idx_o)
    );

    task automatic check_out(input bit ef, input int ei, input string tag);
        n_chk++;
        if (fault_o !== ef || int'(fault_idx_o) != ei) begin
            n_fail++;
            $display("FAIL %s: fault=%0b idx=%0d expected fault=%0b idx=%0d",
                     tag, fault_o, fault_idx_o, ef, ei);
        end
    endtask

    // One cycle: drive an operation, advance the model, compare outputs.
    task automatic step(input bit v, input longint a, input int s, input bit se,
                        input int si, input logic [N-1:0] m, input bit fl,
                        input string tag);
        bit nf;
        int ni;
        longint ohi;
        @(negedge clk);
        op_valid_i    = v;
        op_addr_i     = a[31:0];
        op_size_i     = s[1:0];
        op_set_en_i   = se;
        op_set_idx_i  = si[3:0];
        op_chk_mask_i = m;
        flush_i       = fl;
        nf = 1'b0;
        ni = 0;
        ohi = a + (longint'(1) << s) - 1;
        if (fl || m_fault) begin
            for (int k = 0; k < N; k++) m_vld[k] = 1'b0;
        end else if (v) begin
            for (int k = N - 1; k >= 0; k--) begin
                if (m[k] && m_vld[k] &&
                    m_base[k] <= ohi &&
                    a <= m_base[k] + (longint'(1) << m_lg[k]) - 1) begin
                    nf = 1'b1;
                    ni = k;
                end
            end
            if (se && si < N) begin
                m_vld[si]  = 1'b1;
                m_base[si] = a;
                m_lg[si]   = s;
            end
        end
        @(posedge clk);
        #1;
        m_fault = nf;
        m_idx   = ni;
        check_out(nf, ni, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 0, 1'b0, 0, '0, 1'b0, tag);
    endtask

    localparam logic [N-1:0] ALL = '1;

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            m_vld[k] = 1'b0; m_base[k] = 0; m_lg[k] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        check_out(1'b0, 0, "R1 in reset");
        @(negedge clk);
        rst_ni = 1'b1;
        // R1: empty file after reset
        step(1'b1, 0, 3, 1'b0, 0, ALL, 1'b0, "R1 empty check");
        step(1'b1, 32'hFFFF_FFF8, 3, 1'b0, 0, ALL, 1'b0, "R1 empty check high");

        // R3 / R4 sweep over sizes and offsets around a stored range
        for (int s1 = 0; s1 < 4; s1++) begin
            for (int s2 = 0; s2 < 4; s2++) begin
                for (int off = -9; off <= 9; off++) begin
                    step(1'b1, 64, s1, 1'b1, 5, '0, 1'b0, "R2 store");
                    step(1'b1, 64 + off, s2, 1'b0, 0, ALL & ~(N'(1) << 5), 1'b0, "R4 unselected");
                    step(1'b1, 64 + off, s2, 1'b0, 0, N'(1) << 5, 1'b0, "R3 overlap");
                    idle("R7 after check");
                end
            end
        end

        // R3: no wrap past the top of the address space
        step(1'b1, 32'hFFFF_FFFE, 3, 1'b1, 12, '0, 1'b0, "R2 store high");
        step(1'b1, 0, 2, 1'b0, 0, ALL, 1'b0, "R3 no wrap");
        step(1'b1, 32'hFFFF_FFFF, 0, 1'b0, 0, ALL, 1'b0, "R3 top byte");
        idle("R7 wipe");

        // R6: lowest matching index wins
        step(1'b1, 200, 2, 1'b1, 9, '0, 1'b0, "R2 store 9");
        step(1'b1, 200, 2, 1'b1, 4, '0, 1'b0, "R2 store 4");
        step(1'b1, 200, 2, 1'b1, 11, '0, 1'b0, "R2 store 11");
        step(1'b1, 201, 0, 1'b0, 0, ALL, 1'b0, "R6 lowest index");
        // R7: operation during fault cycle is dropped
        step(1'b1, 200, 0, 1'b1, 2, ALL, 1'b0, "R7 op in fault cycle");
        step(1'b1, 200, 3, 1'b0, 0, ALL, 1'b0, "R7 file emptied");
        for (int k = 0; k < N; k++) begin
            step(1'b1, 1024 + 16 * k, 2, 1'b1, k, '0, 1'b0, "R2 fill");
        end
        for (int k = N - 1; k >= 0; k--) begin
            step(1'b1, 1024 + 16 * k + 3, 0, 1'b0, 0, ALL, 1'b0, "R6 each slot");
            idle("R7 wipe");
        end

        // R5: check sees contents before same-cycle store
        step(1'b1, 300, 2, 1'b1, 1, '0, 1'b0, "R2 store 1");
        step(1'b1, 300, 2, 1'b1, 3, N'(1) << 3, 1'b0, "R5 old contents");
        step(1'b1, 302, 0, 1'b0, 0, N'(1) << 3, 1'b0, "R5 visible next cycle");
        idle("R7 wipe");

        // R8: flush wins over a same-cycle operation
        step(1'b1, 40, 0, 1'b1, 0, '0, 1'b0, "R2 store 0");
        step(1'b1, 40, 0, 1'b1, 6, ALL, 1'b1, "R8 flush with op");
        step(1'b1, 40, 0, 1'b0, 0, ALL, 1'b0, "R8 flushed");
        step(1'b1, 40, 0, 1'b1, 6, '0, 1'b0, "R2 store 6");
        step(1'b0, 0, 0, 1'b0, 0, '0, 1'b1, "R8 flush alone");
        step(1'b1, 40, 0, 1'b0, 0, ALL, 1'b0, "R8 flushed again");

        // R9: out-of-range index and invalid operations store nothing
        step(1'b1, 700, 1, 1'b1, 14, '0, 1'b0, "R9 idx 14");
        step(1'b1, 700, 1, 1'b1, 15, '0, 1'b0, "R9 idx 15");
        step(1'b0, 800, 1, 1'b1, 2, ALL, 1'b0, "R9 invalid op");
        step(1'b1, 700, 1, 1'b0, 0, ALL, 1'b0, "R9 nothing stored");
        step(1'b1, 800, 1, 1'b0, 0, ALL, 1'b0, "R9 nothing stored invalid");

        // R10: a store replaces earlier contents
        step(1'b1, 1000, 0, 1'b1, 7, '0, 1'b0, "R2 store 7");
        step(1'b1, 2000, 0, 1'b1, 7, '0, 1'b0, "R10 overwrite 7");
        step(1'b1, 1000, 0, 1'b0, 0, N'(1) << 7, 1'b0, "R10 old range gone");
        step(1'b1, 2000, 0, 1'b0, 0, N'(1) << 7, 1'b0, "R10 new range hit");
        idle("R7 wipe");
        idle("R6 quiet");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule